// File: doc/BRIEF.md
# Shift-Pair and Bit-Field Extract Unit

This block is the datapath for one opcode group of a 32-bit RISC core. It takes an instruction word, the values of the two registers that the word names, and a 5-bit shift-amount register. From these it produces the destination register index, a 32-bit result and a 3-bit condition code that a later stage uses to decide whether to nullify the next instruction. Four operations share the group. Two are funnel right shifts of a register pair, one by the shift-amount register and one by an immediate. Two are bit-field extracts, one at the position held in the shift-amount register and one at an immediate position. Each extract zero-extends or sign-extends its field as the word selects.

Operands arrive on a valid/ready stream and results leave on a second valid/ready stream, with one register stage between them. `in_ready` is high when the output slot is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds its value. The register file, the evaluation of the nullify condition and the pipeline control sit outside the block. The register file must present on `opnd_x` the value of the register named in bits 25:21 and on `opnd_y` the value of the register named in bits 20:16.

Top module: `fieldshift_unit`

## Requirements
- R1: After a synchronous reset `out_valid` is 0 and `in_ready` is 1.
- R2: A word is accepted when `in_valid` and `in_ready` are both high, and its result appears with `out_valid` high on the next cycle. `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` is high and `out_ready` is low, all outputs hold their values.
- R3: The variable shift-pair form (bits 31:26 = 0x34, bits 12:5 all zero) forms a 64-bit value with `opnd_y` in the upper half and `opnd_x` in the lower half. It shifts that value right by `sar` and returns the low 32 bits. The destination is bits 4:0. If both register indices are equal, the result is a rotate right of the operand.
- R4: The immediate shift-pair form (bits 31:26 = 0x34, bits 12:10 = 3'b010) shifts the same pair right by 31 minus bits 9:5. The destination is bits 4:0.
- R5: In either shift-pair form, a register index of 0 in bits 20:16 makes the upper half zero whatever `opnd_y` carries, giving a logical right shift of `opnd_x`.
- R6: The variable extract form (bits 31:26 = 0x34, bits 12:11 = 2'b10, bits 9:5 all zero) takes from `opnd_x` a field that starts at bit (`sar` XOR 31) and is 32 minus bits 4:0 long. Bits beyond bit 31 read as zero. With bit 10 = 0 the field is zero-extended. The destination is bits 20:16.
- R7: In either extract form, bit 10 = 1 sign-extends the field from its top bit, and bits beyond bit 31 of the source read as `opnd_x[31]`.
- R8: The immediate extract form (bits 31:26 = 0x34, bits 12:11 = 2'b11) works like R6 and R7, with the field starting at bit 31 minus bits 9:5.
- R9: For every recognised word, `out_cond` carries bits 15:13 of that word.
- R10: A word that matches none of the four encodings sets `out_illegal` to 1 and `out_wen` to 0, with `out_result` and `out_cond` zero. A recognised word sets `out_wen` to 1 and `out_illegal` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word and operands are valid |
| in_ready | output | 1 | Block can take an input this cycle |
| insn | input | 32 | Instruction word |
| opnd_x | input | 32 | Value of register named in bits 25:21 |
| opnd_y | input | 32 | Value of register named in bits 20:16 |
| sar | input | 5 | Shift-amount register |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_wen | output | 1 | Register write enable for the result |
| out_illegal | output | 1 | Word matched no encoding of the group |
| out_rd | output | 5 | Destination register index |
| out_result | output | 32 | Result value |
| out_cond | output | 3 | Nullify condition code passed through |

## Verification
The assertions assume that the consumer drives `out_ready` as a plain level and that the producer keeps `in_valid` and its operands steady until they are taken. The bench follows both rules: it keeps an offered word unchanged until `in_ready` lets it through, and it draws `out_ready` at random only after a directed opening phase. The assertions do not assume that the register file reads index 0 as zero, and the stimulus feeds nonzero `opnd_y` values with index 0 so that R5 is tested by the block alone. When both indices are equal, the stimulus copies `opnd_x` into `opnd_y` to model a consistent register file.

// File: rtl/fsx_pkg.sv
package fsx_pkg;
  localparam int INSN_W  = 32;
  localparam int NUM_PAT = 4;

  typedef enum logic [2:0] {
    OP_SHP_VAR = 3'd0,
    OP_SHP_IMM = 3'd1,
    OP_EXT_VAR = 3'd2,
    OP_EXT_IMM = 3'd3,
    OP_NONE    = 3'd4
  } op_e;

  // Encoding table; the index of each entry equals its op_e value.
  function automatic logic [INSN_W-1:0] pat_match(input int idx);
    case (idx)
      0:       return 32'hd000_0000;
      1:       return 32'hd000_0800;
      2:       return 32'hd000_1000;
      default: return 32'hd000_1800;
    endcase
  endfunction

  function automatic logic [INSN_W-1:0] pat_mask(input int idx);
    case (idx)
      0:       return 32'hfc00_1fe0;
      1:       return 32'hfc00_1c00;
      2:       return 32'hfc00_1be0;
      default: return 32'hfc00_1800;
    endcase
  endfunction

  typedef struct packed {
    op_e        op;
    logic [4:0] rd;
    logic       hi_zero;
    logic [4:0] imm5;
    logic [4:0] clen;
    logic       sext;
    logic [2:0] cond;
  } dec_t;
endpackage

// File: rtl/fsx_decode.sv
module fsx_decode
  import fsx_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output dec_t              dec
);
  logic [NUM_PAT-1:0] hit;

  for (genvar g = 0; g < NUM_PAT; g++) begin : g_pat
    assign hit[g] = ((insn & pat_mask(g)) == pat_match(g));
  end

  always_comb begin
    dec.op = OP_NONE;
    for (int i = NUM_PAT - 1; i >= 0; i--) begin
      if (hit[i]) dec.op = op_e'(i);
    end
    dec.rd      = (dec.op == OP_SHP_VAR || dec.op == OP_SHP_IMM) ? insn[4:0] : insn[20:16];
    dec.hi_zero = (insn[20:16] == 5'd0);
    dec.imm5    = insn[9:5];
    dec.clen    = insn[4:0];
    dec.sext    = insn[10];
    dec.cond    = insn[15:13];
  end
endmodule

// File: rtl/fsx_funnel.sv
module fsx_funnel #(
  parameter int W = 32,
  localparam int SH_W = $clog2(W)
) (
  input  logic [W-1:0]    hi,
  input  logic [W-1:0]    lo,
  input  logic [SH_W-1:0] amt,
  output logic [W-1:0]    res
);
  logic [2*W-1:0] pair;
  logic [2*W-1:0] moved;

  always_comb begin
    pair  = {hi, lo};
    moved = pair >> amt;
    res   = moved[W-1:0];
  end
endmodule

// File: rtl/fsx_extract.sv
module fsx_extract #(
  parameter int W = 32,
  localparam int SH_W = $clog2(W)
) (
  input  logic [W-1:0]    src,
  input  logic [SH_W-1:0] pos,
  input  logic [SH_W-1:0] clen,
  input  logic            sext,
  output logic [W-1:0]    res
);
  logic [SH_W:0]   len;
  logic [SH_W-1:0] top_idx;
  logic [W-1:0]    moved;
  logic [W-1:0]    keep;
  logic            top_bit;

  always_comb begin
    len     = (SH_W+1)'(W) - {1'b0, clen};
    top_idx = SH_W'(len - 1'b1);
    if (sext) moved = W'($signed(src) >>> pos);
    else      moved = src >> pos;
    if (len == (SH_W+1)'(W)) keep = '1;
    else                     keep = (W'(1) << len) - W'(1);
    top_bit = moved[top_idx];
    res     = (moved & keep) | ((sext && top_bit) ? ~keep : '0);
  end
endmodule

// File: rtl/fieldshift_unit.sv
module fieldshift_unit
  import fsx_pkg::*;
#(
  parameter int W = 32,
  localparam int SH_W = $clog2(W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] insn,
  input  logic [W-1:0]      opnd_x,
  input  logic [W-1:0]      opnd_y,
  input  logic [SH_W-1:0]   sar,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_wen,
  output logic              out_illegal,
  output logic [4:0]        out_rd,
  output logic [W-1:0]      out_result,
  output logic [2:0]        out_cond
);
  localparam logic [SH_W-1:0] MSB_IDX = SH_W'(W - 1);

  dec_t            dec;
  logic [W-1:0]    hi_val;
  logic [SH_W-1:0] sh_amt;
  logic [SH_W-1:0] ex_pos;
  logic [W-1:0]    sh_res;
  logic [W-1:0]    ex_res;
  logic [W-1:0]    nxt_res;
  logic            legal;
  logic            take;

  fsx_decode u_dec (
    .insn (insn),
    .dec  (dec)
  );

  // Shift pair: variable amount is used as is, immediate amount is 31 - field.
  assign hi_val = dec.hi_zero ? '0 : opnd_y;
  assign sh_amt = (dec.op == OP_SHP_VAR) ? sar : (dec.imm5 ^ MSB_IDX);

  fsx_funnel #(.W(W)) u_fun (
    .hi  (hi_val),
    .lo  (opnd_x),
    .amt (sh_amt),
    .res (sh_res)
  );

  // Extract: both position sources count from the top bit.
  assign ex_pos = ((dec.op == OP_EXT_VAR) ? sar : dec.imm5) ^ MSB_IDX;

  fsx_extract #(.W(W)) u_ext (
    .src  (opnd_x),
    .pos  (ex_pos),
    .clen (dec.clen),
    .sext (dec.sext),
    .res  (ex_res)
  );

  always_comb begin
    case (dec.op)
      OP_SHP_VAR, OP_SHP_IMM: nxt_res = sh_res;
      OP_EXT_VAR, OP_EXT_IMM: nxt_res = ex_res;
      default:                nxt_res = '0;
    endcase
  end

  assign legal    = (dec.op != OP_NONE);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_wen     <= 1'b0;
      out_illegal <= 1'b0;
      out_rd      <= '0;
      out_result  <= '0;
      out_cond    <= '0;
    end else begin
      if (take) begin
        out_valid   <= 1'b1;
        out_wen     <= legal;
        out_illegal <= !legal;
        out_rd      <= legal ? dec.rd : 5'd0;
        out_result  <= nxt_res;
        out_cond    <= legal ? dec.cond : 3'd0;
      end else if (out_ready) begin
        out_valid   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fsx_checker.sv
module fsx_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic         out_wen,
  input logic         out_illegal,
  input logic [4:0]   out_rd,
  input logic [W-1:0] out_result,
  input logic [2:0]   out_cond
);
  // R2: an accepted word shows up on the next cycle
  a_r2_accept_next: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R2: a stalled result holds every field
  a_r2_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_rd)
      && $stable(out_cond) && $stable(out_wen) && $stable(out_illegal)));

  // R2: a drained slot with no new word empties
  a_r2_drain_empty: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && out_ready) |=> !out_valid);

  // R10: an unmatched word never writes and carries zero data
  a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (!out_wen && out_result == '0 && out_cond == 3'd0));

  // R10: write enable and illegal flag are exclusive on a valid result
  a_r10_flag_excl: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot({out_wen, out_illegal}));
endmodule

bind fieldshift_unit fsx_checker #(.W(W)) u_fsx_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_wen     (out_wen),
  .out_illegal (out_illegal),
  .out_rd      (out_rd),
  .out_result  (out_result),
  .out_cond    (out_cond)
);

// File: tb/tb_fieldshift_unit.sv
module tb_fieldshift_unit;
  localparam int CLK_PERIOD = 10;
  localparam int N_TXN      = 600;
  localparam int WD_LIMIT   = 50000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] insn = '0;
  logic [31:0] opnd_x = '0;
  logic [31:0] opnd_y = '0;
  logic [4:0]  sar = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_wen;
  logic        out_illegal;
  logic [4:0]  out_rd;
  logic [31:0] out_result;
  logic [2:0]  out_cond;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct {
    logic [31:0] res;
    logic [4:0]  rd;
    logic        wen;
    logic        ill;
    logic [2:0]  cond;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  fieldshift_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .insn(insn),
    .opnd_x(opnd_x), .opnd_y(opnd_y), .sar(sar), .out_valid(out_valid),
    .out_ready(out_ready), .out_wen(out_wen), .out_illegal(out_illegal),
    .out_rd(out_rd), .out_result(out_result), .out_cond(out_cond)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] enc(input int form, input int r2, input int r1, input int c,
                                      input int imm, input int b10, input int low);
    logic [1:0] sub = 2'(form);
    return {6'h34, 5'(r2), 5'(r1), 3'(c), sub, 1'(b10), 5'(imm), 5'(low)};
  endfunction

  // Bit-by-bit model built from the requirements.
  function automatic exp_t model(input logic [31:0] w, input logic [31:0] x,
                                 input logic [31:0] y, input logic [4:0] s);
    exp_t e;
    int   kind;
    int   amt, p, len;
    logic [31:0] hi;
    logic se;
    e.res = '0; e.rd = '0; e.wen = 0; e.ill = 1; e.cond = '0; e.tag = "R10";
    kind = 4;
    if (w[31:26] == 6'h34) begin
      case (w[12:11])
        2'b00: if (w[10:5] == 6'd0) kind = 0;
        2'b01: if (w[10] == 1'b0) kind = 1;
        2'b10: if (w[9:5] == 5'd0) kind = 2;
        default: kind = 3;
      endcase
    end
    if (kind == 4) return e;
    e.wen = 1; e.ill = 0; e.cond = w[15:13];
    if (kind < 2) begin
      amt  = (kind == 0) ? int'(s) : 31 - int'(w[9:5]);
      hi   = (w[20:16] == 5'd0) ? 32'd0 : y;
      e.rd = w[4:0];
      for (int i = 0; i < 32; i++)
        e.res[i] = (i + amt < 32) ? x[i + amt] : hi[i + amt - 32];
      e.tag = (w[20:16] == 5'd0) ? "R5" : (kind == 0 ? "R3" : "R4");
    end else begin
      p    = (kind == 2) ? (31 - int'(s)) : (31 - int'(w[9:5]));
      len  = 32 - int'(w[4:0]);
      se   = w[10];
      e.rd = w[20:16];
      for (int i = 0; i < 32; i++) begin
        if (i < len) e.res[i] = (p + i < 32) ? x[p + i] : (se ? x[31] : 1'b0);
        else         e.res[i] = se ? e.res[len - 1] : 1'b0;
      end
      e.tag = se ? "R7" : (kind == 2 ? "R6" : "R8");
    end
    return e;
  endfunction

  task automatic make_txn(input int i);
    opnd_x = $urandom; opnd_y = $urandom; sar = 5'($urandom);
    case (i)
      0:  begin insn = enc(0, 5, 3, 0, 0, 0, 9);  opnd_y = 32'h11223344; opnd_x = 32'h55667788; sar = 5'd8; end
      1:  begin insn = enc(0, 5, 0, 0, 0, 0, 2);  opnd_y = 32'hFFFFFFFF; opnd_x = 32'h80000000; sar = 5'd4; end
      2:  begin insn = enc(0, 7, 7, 0, 0, 0, 1);  opnd_x = 32'h12345678; opnd_y = opnd_x; sar = 5'd4; end
      3:  begin insn = enc(1, 4, 6, 0, 31, 0, 3); opnd_x = 32'hCAFEF00D; opnd_y = 32'h0; end
      4:  begin insn = enc(1, 4, 6, 0, 0, 0, 3);  opnd_x = 32'hFFFFFFFE; opnd_y = 32'h1; end
      5:  begin insn = enc(2, 8, 10, 0, 0, 0, 24); opnd_x = 32'h0000AB00; sar = 5'd23; end
      6:  begin insn = enc(2, 8, 10, 0, 0, 1, 24); opnd_x = 32'h0000AB00; sar = 5'd23; end
      7:  begin insn = enc(3, 8, 11, 0, 31, 1, 0); opnd_x = 32'h87654321; end
      8:  begin insn = enc(3, 8, 11, 0, 3, 1, 8);  opnd_x = 32'h80000000; end
      9:  insn = 32'h0000_0000;
      10: insn = enc(0, 1, 2, 5, 0, 0, 4);
      11: insn = 32'hD000_0020;
      12: begin insn = enc(0, 1, 2, 0, 0, 0, 4); sar = 5'd0; end
      default: begin
        int form = int'($urandom % 4);
        insn = $urandom;
        if ($urandom % 4 != 0) begin
          insn[31:26] = 6'h34;
          insn[12:11] = 2'(form);
          if ($urandom % 4 != 0) begin
            if (form == 0) insn[10:5] = '0;
            if (form == 1) insn[10] = 1'b0;
            if (form == 2) insn[9:5] = '0;
          end
          if ($urandom % 8 == 0) insn[20:16] = '0;
          if ($urandom % 5 == 0) begin insn[20:16] = insn[25:21]; opnd_y = opnd_x; end
        end
      end
    endcase
  endtask

  initial begin : wd
    repeat (WD_LIMIT) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%08h expected=%08h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    bit pending = 0;
    bit have_ov = 0;
    bit exp_ov = 0;
    bit hold = 0;
    bit acc;
    logic [31:0] h_res; logic [4:0] h_rd; logic [2:0] h_cond;
    int idx = 0;
    exp_t e;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", 32'(in_ready), 32'd1);
    while (idx < N_TXN || pending || exp_q.size() != 0) begin
      @(negedge clk);
      if (have_ov)
        check(out_valid == exp_ov, "R2", "out_valid timing", 32'(out_valid), 32'(exp_ov));
      if (hold) begin
        check(out_result == h_res && out_rd == h_rd && out_cond == h_cond, "R2",
              "stall hold", out_result, h_res);
      end
      if (!pending && idx < N_TXN) begin
        make_txn(idx);
        idx++;
        pending  = 1;
        in_valid = 1'b1;
      end else if (!pending) begin
        in_valid = 1'b0;
      end
      out_ready = (idx < 20) ? 1'b1 : ($urandom % 4 != 0);
      #1;
      check(in_ready == (!out_valid || out_ready), "R2", "in_ready rule",
            32'(in_ready), 32'(!out_valid || out_ready));
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", "unexpected output", out_result, 32'd0);
        end else begin
          e = exp_q.pop_front();
          check(out_result == e.res, e.tag, "result", out_result, e.res);
          check(out_wen == e.wen && out_illegal == e.ill && out_rd == e.rd,
                e.ill ? "R10" : e.tag, "wen/illegal/rd",
                {22'd0, out_wen, out_illegal, 3'd0, out_rd},
                {22'd0, e.wen, e.ill, 3'd0, e.rd});
          check(out_cond == e.cond, e.ill ? "R10" : "R9", "cond", 32'(out_cond), 32'(e.cond));
        end
      end
      hold   = out_valid && !out_ready;
      h_res  = out_result; h_rd = out_rd; h_cond = out_cond;
      acc    = in_valid && in_ready;
      if (acc) begin
        exp_q.push_back(model(insn, opnd_x, opnd_y, sar));
        pending = 0;
      end
      exp_ov  = acc || (out_valid && !out_ready);
      have_ov = 1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule